// File: doc/BRIEF.md
# Two-Port Memory with Mailbox Doorbells

This block is a 4096 x 8 memory with two independent ports, called left and right, plus one doorbell interrupt per port. Each port can read or write any word on each clock edge. The memory is synchronous: a read is sampled at a rising edge, and its data appears on that port's read bus right after that edge.

The two highest addresses work as mailboxes. When one port writes the mailbox word that belongs to the other port, the other port's interrupt goes active. That port then reads its own mailbox word, which clears its interrupt. The byte stored in a mailbox is ordinary memory content, so the sender can leave a message there for the receiver to pick up.

Reset is synchronous and active high. It makes both interrupts inactive and sets both read buses to zero. Memory contents are not initialised.

Top module: `dpmb_top`

## Requirements
- R1: While reset is held, at the first edge and after it, both interrupt outputs are high (inactive) and both read buses read 0x00.
- R2: A port writes wdata to addr at an edge where en=1 and we=1. A later read of that address by either port returns the data. Read data appears on the port's rdata bus after the edge that samples the read.
- R3: A read happens only at an edge where en=1, oe=1 and we=0. At any other edge rdata keeps its previous value.
- R4: An edge with en=0 writes nothing, even when we=1.
- R5: A left-port write to address 0xFFF drives the right interrupt irq_r_n low after that edge.
- R6: A right-port read of 0xFFF makes irq_r_n high after that edge. A left-port read of 0xFFF leaves irq_r_n unchanged.
- R7: A right-port write to address 0xFFE drives the left interrupt irq_l_n low after that edge.
- R8: A left-port read of 0xFFE makes irq_l_n high after that edge. A right-port read of 0xFFE leaves irq_l_n unchanged.
- R9: If a flag is set and cleared at the same edge, it ends up set, so the interrupt stays low or goes low.
- R10: If one port writes an address and the other port reads that address at the same edge, the read returns the word held before the write.
- R11: The mailbox words at 0xFFE and 0xFFF store and return data like any other address.
- R12: If both ports write the same address at the same edge, the left port's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_l | input | 1 | Left port enable |
| oe_l | input | 1 | Left port output enable |
| we_l | input | 1 | Left port direction: 1 = write, 0 = read |
| addr_l | input | 12 | Left port word address |
| wdata_l | input | 8 | Left port write data |
| rdata_l | output | 8 | Left port read data |
| irq_l_n | output | 1 | Left doorbell interrupt, active low |
| en_r | input | 1 | Right port enable |
| oe_r | input | 1 | Right port output enable |
| we_r | input | 1 | Right port direction: 1 = write, 0 = read |
| addr_r | input | 12 | Right port word address |
| wdata_r | input | 8 | Right port write data |
| rdata_r | output | 8 | Right port read data |
| irq_r_n | output | 1 | Right doorbell interrupt, active low |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it. Read data, interrupt sets and interrupt clears each come from a single register stage. The bench changes its inputs on the falling edge, so the next rising edge samples them. It checks the outputs on the falling edge after that, half a period after they have settled. Cases where several events land on the same edge use one shared drive step for both ports, so both requests reach the same edge. Those cases are a set and a clear together, a write and a read of the same address, and two writes to one address.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NPORTS = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

    // raw pins of one port
    typedef struct packed {
        logic  en;
        logic  oe;
        logic  we;
        addr_t addr;
        data_t wdata;
    } port_in_t;

    // qualified access of one port for this edge
    typedef struct packed {
        logic  rd;
        logic  wr;
        addr_t addr;
        data_t wdata;
    } access_t;

    // mailbox word whose read clears the given side's flag
    function automatic addr_t own_mailbox(side_e s);
        addr_t top;
        top = '1;
        return (s == SIDE_R) ? top : top - addr_t'(1);
    endfunction

    function automatic side_e peer_of(side_e s);
        return (s == SIDE_L) ? SIDE_R : SIDE_L;
    endfunction

    function automatic access_t qualify(port_in_t p);
        access_t a;
        a.rd    = p.en && p.oe && !p.we;
        a.wr    = p.en && p.we;
        a.addr  = p.addr;
        a.wdata = p.wdata;
        return a;
    endfunction

endpackage

// File: rtl/dpmb_port_decode.sv
module dpmb_port_decode
    import dpmb_pkg::*;
#(
    parameter side_e SIDE = SIDE_L
) (
    input  port_in_t pins,
    output access_t  acc,
    output logic     own_mb_read,
    output logic     peer_mb_write
);
    localparam addr_t OWN_MB  = own_mailbox(SIDE);
    localparam addr_t PEER_MB = own_mailbox(peer_of(SIDE));

    always_comb begin
        acc           = qualify(pins);
        own_mb_read   = acc.rd && (acc.addr == OWN_MB);
        peer_mb_write = acc.wr && (acc.addr == PEER_MB);
    end
endmodule

// File: rtl/dpmb_mem.sv
module dpmb_mem
    import dpmb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  access_t acc_l,
    input  access_t acc_r,
    output data_t   rdata_l,
    output data_t   rdata_r
);
    data_t mem [DEPTH];

    // right written first so a left write to the same word overrides it
    always_ff @(posedge clk) begin
        if (acc_r.wr) mem[acc_r.addr] <= acc_r.wdata;
        if (acc_l.wr) mem[acc_l.addr] <= acc_l.wdata;
    end

    // reads take the value from before this edge's writes
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_l <= '0;
            rdata_r <= '0;
        end else begin
            if (acc_l.rd) rdata_l <= mem[acc_l.addr];
            if (acc_r.rd) rdata_r <= mem[acc_r.addr];
        end
    end
endmodule

// File: rtl/dpmb_flag.sv
module dpmb_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq_n
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)      pend_q <= 1'b0;
        else if (set) pend_q <= 1'b1;
        else if (clr) pend_q <= 1'b0;
    end

    assign irq_n = ~pend_q;
endmodule

// File: rtl/dpmb_top.sv
module dpmb_top
    import dpmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_l,
    input  logic              oe_l,
    input  logic              we_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [DATA_W-1:0] wdata_l,
    output logic [DATA_W-1:0] rdata_l,
    output logic              irq_l_n,
    input  logic              en_r,
    input  logic              oe_r,
    input  logic              we_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] wdata_r,
    output logic [DATA_W-1:0] rdata_r,
    output logic              irq_r_n
);
    port_in_t pins      [NPORTS];
    access_t  acc       [NPORTS];
    logic     mb_rd     [NPORTS];
    logic     mb_ring   [NPORTS];
    logic     irq_n_vec [NPORTS];

    always_comb begin
        pins[SIDE_L] = '{en: en_l, oe: oe_l, we: we_l, addr: addr_l, wdata: wdata_l};
        pins[SIDE_R] = '{en: en_r, oe: oe_r, we: we_r, addr: addr_r, wdata: wdata_r};
    end

    for (genvar s = 0; s < NPORTS; s++) begin : g_side
        localparam side_e SD = side_e'(s);
        localparam int    PR = int'(peer_of(SD));

        dpmb_port_decode #(.SIDE(SD)) u_dec (
            .pins          (pins[s]),
            .acc           (acc[s]),
            .own_mb_read   (mb_rd[s]),
            .peer_mb_write (mb_ring[s])
        );

        dpmb_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set   (mb_ring[PR]),
            .clr   (mb_rd[s]),
            .irq_n (irq_n_vec[s])
        );
    end

    dpmb_mem u_mem (
        .clk     (clk),
        .rst     (rst),
        .acc_l   (acc[SIDE_L]),
        .acc_r   (acc[SIDE_R]),
        .rdata_l (rdata_l),
        .rdata_r (rdata_r)
    );

    assign irq_l_n = irq_n_vec[SIDE_L];
    assign irq_r_n = irq_n_vec[SIDE_R];
endmodule

// File: rtl/dpmb_checker.sv
module dpmb_checker
    import dpmb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en_l,
    input logic              oe_l,
    input logic              we_l,
    input logic [ADDR_W-1:0] addr_l,
    input logic [DATA_W-1:0] rdata_l,
    input logic              irq_l_n,
    input logic              en_r,
    input logic              oe_r,
    input logic              we_r,
    input logic [ADDR_W-1:0] addr_r,
    input logic [DATA_W-1:0] rdata_r,
    input logic              irq_r_n
);
    localparam addr_t MB_R = '1;
    localparam addr_t MB_L = MB_R - addr_t'(1);

    logic rd_l, rd_r, ring_r, ring_l, clr_r, clr_l;
    assign rd_l   = en_l && oe_l && !we_l;
    assign rd_r   = en_r && oe_r && !we_r;
    assign ring_r = en_l && we_l && addr_l == MB_R;
    assign ring_l = en_r && we_r && addr_r == MB_L;
    assign clr_r  = rd_r && addr_r == MB_R;
    assign clr_l  = rd_l && addr_l == MB_L;

    p_ring_right_r5: assert property (@(posedge clk) disable iff (rst)
        ring_r |=> !irq_r_n);
    p_ring_left_r7: assert property (@(posedge clk) disable iff (rst)
        ring_l |=> !irq_l_n);
    p_ack_right_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_r && !ring_r) |=> irq_r_n);
    p_ack_left_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_l && !ring_l) |=> irq_l_n);
    p_hold_right_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr_r && !ring_r) |=> $stable(irq_r_n));
    p_hold_left_r8: assert property (@(posedge clk) disable iff (rst)
        (!clr_l && !ring_l) |=> $stable(irq_l_n));
    p_rd_hold_l_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_l |=> $stable(rdata_l));
    p_rd_hold_r_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_r |=> $stable(rdata_r));
endmodule

bind dpmb_top dpmb_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_l    (en_l),
    .oe_l    (oe_l),
    .we_l    (we_l),
    .addr_l  (addr_l),
    .rdata_l (rdata_l),
    .irq_l_n (irq_l_n),
    .en_r    (en_r),
    .oe_r    (oe_r),
    .we_r    (we_r),
    .addr_r  (addr_r),
    .rdata_r (rdata_r),
    .irq_r_n (irq_r_n)
);

// File: tb/tb_dpmb_top.sv
module tb_dpmb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_l = 0, oe_l = 0, we_l = 0;
    logic [11:0] addr_l = '0;
    logic [7:0] wdata_l = '0;
    logic [7:0] rdata_l;
    logic       irq_l_n;
    logic       en_r = 0, oe_r = 0, we_r = 0;
    logic [11:0] addr_r = '0;
    logic [7:0] wdata_r = '0;
    logic [7:0] rdata_r;
    logic       irq_r_n;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dpmb_top dut (
        .clk(clk), .rst(rst),
        .en_l(en_l), .oe_l(oe_l), .we_l(we_l), .addr_l(addr_l),
        .wdata_l(wdata_l), .rdata_l(rdata_l), .irq_l_n(irq_l_n),
        .en_r(en_r), .oe_r(oe_r), .we_r(we_r), .addr_r(addr_r),
        .wdata_r(wdata_r), .rdata_r(rdata_r), .irq_r_n(irq_r_n)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        en_l = 0; oe_l = 0; we_l = 0;
        en_r = 0; oe_r = 0; we_r = 0;
    endtask

    // one edge: inputs set on falling edge, outputs checked on next falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_l(input logic e, input logic o, input logic w,
                         input logic [11:0] a, input logic [7:0] d);
        en_l = e; oe_l = o; we_l = w; addr_l = a; wdata_l = d;
    endtask

    task automatic set_r(input logic e, input logic o, input logic w,
                         input logic [11:0] a, input logic [7:0] d);
        en_r = e; oe_r = o; we_r = w; addr_r = a; wdata_r = d;
    endtask

    task automatic wr_l(input logic [11:0] a, input logic [7:0] d);
        idle(); set_l(1, 0, 1, a, d); step(); idle();
    endtask
    task automatic wr_r(input logic [11:0] a, input logic [7:0] d);
        idle(); set_r(1, 0, 1, a, d); step(); idle();
    endtask
    task automatic rd_l(input logic [11:0] a);
        idle(); set_l(1, 1, 0, a, 8'h00); step(); idle();
    endtask
    task automatic rd_r(input logic [11:0] a);
        idle(); set_r(1, 1, 0, a, 8'h00); step(); idle();
    endtask

    task automatic t_reset();
        check("R1", "irq_l_n in reset", {7'b0, irq_l_n}, 8'h01);
        check("R1", "irq_r_n in reset", {7'b0, irq_r_n}, 8'h01);
        check("R1", "rdata_l in reset", rdata_l, 8'h00);
        check("R1", "rdata_r in reset", rdata_r, 8'h00);
    endtask

    task automatic t_basic();
        wr_l(12'h123, 8'hA5);
        rd_l(12'h123);
        check("R2", "left reads own write", rdata_l, 8'hA5);
        wr_r(12'h456, 8'h3C);
        rd_r(12'h456);
        check("R2", "right reads own write", rdata_r, 8'h3C);
        rd_l(12'h456);
        check("R2", "left reads right write", rdata_l, 8'h3C);
    endtask

    task automatic t_read_gating();
        wr_l(12'h010, 8'h99);
        rd_l(12'h123);              // rdata_l = A5
        idle(); set_l(1, 0, 0, 12'h010, 8'h00); step(); idle();
        check("R3", "oe low holds rdata", rdata_l, 8'hA5);
        idle(); set_l(0, 1, 0, 12'h010, 8'h00); step(); idle();
        check("R3", "en low holds rdata", rdata_l, 8'hA5);
        rd_l(12'h010);
        check("R3", "qualified read updates", rdata_l, 8'h99);
    endtask

    task automatic t_write_gating();
        wr_r(12'h040, 8'h11);
        idle(); set_r(0, 0, 1, 12'h040, 8'hEE); step(); idle();
        rd_r(12'h040);
        check("R4", "disabled write ignored", rdata_r, 8'h11);
    endtask

    task automatic t_left_doorbell();
        wr_l(12'hFFF, 8'h5A);
        check("R5", "irq_r_n after left ring", {7'b0, irq_r_n}, 8'h00);
        check("R5", "irq_l_n untouched", {7'b0, irq_l_n}, 8'h01);
        rd_l(12'hFFF);
        check("R6", "left read keeps irq_r_n", {7'b0, irq_r_n}, 8'h00);
        check("R11", "mailbox FFF data via left", rdata_l, 8'h5A);
        rd_r(12'hFFF);
        check("R6", "right read clears irq_r_n", {7'b0, irq_r_n}, 8'h01);
        check("R11", "mailbox FFF data via right", rdata_r, 8'h5A);
    endtask

    task automatic t_right_doorbell();
        wr_r(12'hFFE, 8'hC3);
        check("R7", "irq_l_n after right ring", {7'b0, irq_l_n}, 8'h00);
        check("R7", "irq_r_n untouched", {7'b0, irq_r_n}, 8'h01);
        rd_r(12'hFFE);
        check("R8", "right read keeps irq_l_n", {7'b0, irq_l_n}, 8'h00);
        rd_l(12'hFFE);
        check("R8", "left read clears irq_l_n", {7'b0, irq_l_n}, 8'h01);
        check("R11", "mailbox FFE data", rdata_l, 8'hC3);
    endtask

    task automatic t_set_wins();
        idle();
        set_l(1, 0, 1, 12'hFFF, 8'h77);
        set_r(1, 1, 0, 12'hFFF, 8'h00);
        step(); idle();
        check("R9", "set beats clear right", {7'b0, irq_r_n}, 8'h00);
        check("R10", "right got old mailbox byte", rdata_r, 8'h5A);
        rd_r(12'hFFF);
        check("R6", "later clear right", {7'b0, irq_r_n}, 8'h01);
        check("R11", "new mailbox byte", rdata_r, 8'h77);
        idle();
        set_r(1, 0, 1, 12'hFFE, 8'h21);
        set_l(1, 1, 0, 12'hFFE, 8'h00);
        step(); idle();
        check("R9", "set beats clear left", {7'b0, irq_l_n}, 8'h00);
        rd_l(12'hFFE);
        check("R8", "later clear left", {7'b0, irq_l_n}, 8'h01);
    endtask

    task automatic t_collision();
        wr_l(12'h200, 8'h77);
        idle();
        set_l(1, 0, 1, 12'h200, 8'h88);
        set_r(1, 1, 0, 12'h200, 8'h00);
        step(); idle();
        check("R10", "read during write old", rdata_r, 8'h77);
        rd_r(12'h200);
        check("R10", "write landed", rdata_r, 8'h88);
    endtask

    task automatic t_dual_write();
        idle();
        set_l(1, 0, 1, 12'h300, 8'h01);
        set_r(1, 0, 1, 12'h300, 8'h02);
        step(); idle();
        rd_r(12'h300);
        check("R12", "left wins dual write", rdata_r, 8'h01);
    endtask

    initial begin : wdog
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle();
        step(); step(); step();
        t_reset();
        rst = 1'b0;
        step();
        t_basic();
        t_read_gating();
        t_write_gating();
        t_left_doorbell();
        t_right_doorbell();
        t_set_wins();
        t_collision();
        t_dual_write();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule